// File: doc/BRIEF.md
# UART Register Front-End

This block is the software-visible register face of a simple UART. It holds a receive FIFO and a transmit FIFO of a configurable depth and derives a flag word and a raw interrupt status word from how full each FIFO is. A processor reaches it through a 32-bit register port with byte enables, a size code and an error result. On the line side, two byte streams with a valid/ready handshake stand in for the serializer and deserializer. Bit timing, framing and line errors are handled elsewhere or not at all.

Reading the data register takes one byte from the receive FIFO. Writing the data register puts one byte into the transmit FIFO. The receive-timeout interrupt has no timer. It is raised as soon as receive data is waiting. The interrupt thresholds sit at half the FIFO depth. The busy flag is set only while the transmit FIFO is full.

Top module: `uart_regfront`

## Requirements
- R1: `req_size` is coded 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. Codes 0 to 2 are accepted. A 64-bit request returns `rsp_err`=1 and `rsp_rdata`=0 and has no side effect. Every request is answered one cycle later with `rsp_valid`.
- R2: A write to the data register with `req_be[0]`=1 pushes `req_wdata[7:0]` into the transmit FIFO. When the transmit FIFO is full, the byte is dropped without an error. With `req_be[0]`=0, nothing is pushed.
- R3: A read of the data register returns the oldest received byte and removes it from the receive FIFO. A read while the receive FIFO is empty returns 0 without an error.
- R4: The receive status register always reads 0. Writes to it have no effect.
- R5: Writes to the flag, raw status and masked status registers are ignored. A read of the clear register reports `rsp_err`. Any unmapped offset reads 0 and reports `rsp_err`.
- R6: The word offsets are fixed: data 0x00, receive status 0x04, flags 0x18, mask 0x38, raw status 0x3C, masked status 0x40, clear 0x44. Address bits [1:0] are ignored.
- R7: The flag word reads as follows. Bit 4 means the receive FIFO is empty. Bit 5 means the transmit FIFO is full. Bit 6 means the receive FIFO is full. Bit 7 means the transmit FIFO is empty. Bit 3 (busy) is set only while the transmit FIFO is full.
- R8: The receive interrupt (raw status bit 4) is set by a receive push that brings the fill level to DEPTH-DEPTH/2 or above. It is cleared by a data read that leaves the fill level below that value.
- R9: The transmit interrupt (raw status bit 5) is updated on every accepted transmit push and every transmit drain. It is set when the new fill level is DEPTH-DEPTH/2 or less and cleared otherwise.
- R10: The receive-timeout interrupt (raw status bit 6) is set by every receive push. It is cleared by a data read that empties the receive FIFO.
- R11: The mask register keeps bits 6:4 of a byte-lane-0 write. The masked status reads as raw status AND mask. `irq` is high while the masked status is nonzero. A clear-register write clears the raw bits written as 1. An interrupt event in the same cycle takes priority over the clear.
- R12: After reset, the flag word reads 0x90 and both the raw status and the mask read 0.
- R13: `rx_in_ready` is high while the receive FIFO is not full. `tx_out_valid` is high while the transmit FIFO is not empty, and its data stays stable until it is taken. Both FIFOs keep bytes in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size code |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data |
| rx_in_valid | input | 1 | Received byte offered |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive FIFO can take a byte |
| tx_out_valid | output | 1 | Byte to transmit is available |
| tx_out_data | output | 8 | Byte to transmit |
| tx_out_ready | input | 1 | Serializer takes the byte |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest condition to reach is a full FIFO at the exact moment of a crossing. That covers a transmit write arriving while the FIFO is full, a receive byte offered while `rx_in_ready` is low, and data reads crossing the half-depth threshold and then reaching empty. The stimulus holds the serializer back so the transmit FIFO fills through ordinary data writes. It then sends one more write and later drains the FIFO, checking byte order and the interrupt state afterwards. On the receive side it fills the FIFO to depth, offers one extra byte that must be refused, and reads back one byte at a time. The flags and raw status are checked after each threshold crossing.

// File: rtl/uart_regfront_pkg.sv
// Package: shared encodings for the UART register front-end.
// Holds word offsets, flag and interrupt bit positions, the access-size
// code and the decoded register-select structure.
package uart_regfront_pkg;

    // access size code carried on req_size
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // word index (byte offset / 4) of each register
    localparam int unsigned WIDX_DATA  = 0;
    localparam int unsigned WIDX_RXST  = 1;
    localparam int unsigned WIDX_FLAG  = 6;
    localparam int unsigned WIDX_MASK  = 14;
    localparam int unsigned WIDX_RAW   = 15;
    localparam int unsigned WIDX_MSKD  = 16;
    localparam int unsigned WIDX_CLR   = 17;

    // flag word bit positions
    localparam int unsigned FB_BUSY   = 3;
    localparam int unsigned FB_RXEMP  = 4;
    localparam int unsigned FB_TXFUL  = 5;
    localparam int unsigned FB_RXFUL  = 6;
    localparam int unsigned FB_TXEMP  = 7;

    // interrupt bits: index into the 3-bit status vector, word position = 4 + index
    localparam int unsigned IRQ_LSB   = 4;
    localparam int unsigned IRQ_N     = 3;
    localparam int unsigned IX_RX     = 0;
    localparam int unsigned IX_TX     = 1;
    localparam int unsigned IX_RTO    = 2;

    // one-hot register select produced by the decoder
    typedef struct packed {
        logic data;
        logic rxst;
        logic flag;
        logic mask;
        logic raw;
        logic mskd;
        logic clr;
        logic miss;
    } reg_sel_t;

endpackage

// File: rtl/uart_rf_fifo.sv
// Module: uart_rf_fifo
// Byte FIFO with a fill level output. A push while full and a pop while
// empty are ignored. Assumes DEPTH is a power of two and at least 2.
module uart_rf_fifo #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LW-1:0]     level,
    output logic              empty,
    output logic              full
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // storage write on an accepted push
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer and fill-level tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/uart_rf_decode.sv
// Module: uart_rf_decode
// Maps a byte offset to a one-hot register select. The two low address
// bits are ignored. Any offset that is not mapped sets the miss field.
module uart_rf_decode
    import uart_regfront_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned WW    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    logic [WW-1:0] widx;
    logic          unused_low;

    assign widx       = addr[ADDR_W-1:2];
    assign unused_low = ^addr[1:0];

    // compare the word index against every mapped register
    always_comb begin
        sel      = '0;
        sel.data = (widx == WW'(WIDX_DATA));
        sel.rxst = (widx == WW'(WIDX_RXST));
        sel.flag = (widx == WW'(WIDX_FLAG));
        sel.mask = (widx == WW'(WIDX_MASK));
        sel.raw  = (widx == WW'(WIDX_RAW));
        sel.mskd = (widx == WW'(WIDX_MSKD));
        sel.clr  = (widx == WW'(WIDX_CLR));
        sel.miss = !(sel.data || sel.rxst || sel.flag || sel.mask ||
                     sel.raw || sel.mskd || sel.clr);
    end

endmodule

// File: rtl/uart_rf_irq.sv
// Module: uart_rf_irq
// Holds the three raw interrupt bits. Each bit is set or cleared by FIFO
// events, using the next fill level, and can be cleared from software.
// An event in the same cycle as a software clear takes priority.
// Assumes the push/pop inputs are already qualified by full/empty.
module uart_rf_irq
    import uart_regfront_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned LW   = $clog2(DEPTH) + 1,
    localparam logic [LW-1:0] TH = LW'(DEPTH - DEPTH / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic [LW-1:0]    rx_lvl_nxt,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic [LW-1:0]    tx_lvl_nxt,
    input  logic [IRQ_N-1:0] sw_clr,
    output logic [IRQ_N-1:0] raw
);

    logic [IRQ_N-1:0] raw_nxt;

    // next-state rules for each interrupt source
    always_comb begin
        raw_nxt = raw & ~sw_clr;
        if (rx_push && (rx_lvl_nxt >= TH))
            raw_nxt[IX_RX] = 1'b1;
        else if (rx_pop && (rx_lvl_nxt < TH))
            raw_nxt[IX_RX] = 1'b0;
        if (rx_push)
            raw_nxt[IX_RTO] = 1'b1;
        else if (rx_pop && (rx_lvl_nxt == '0))
            raw_nxt[IX_RTO] = 1'b0;
        if (tx_push || tx_pop)
            raw_nxt[IX_TX] = (tx_lvl_nxt <= TH);
    end

    // raw status register
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= raw_nxt;
    end

endmodule

// File: rtl/uart_regfront.sv
// Module: uart_regfront
// Register front-end of a simple UART. It decodes register accesses,
// moves bytes between the bus and the two FIFOs, builds the flag word and
// drives the interrupt. Every request gets a registered response one cycle
// later. Assumes at most one request per cycle and DEPTH a power of two.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned LW    = $clog2(DEPTH) + 1,
    localparam int unsigned NBYTE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [NBYTE-1:0]  req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic              rx_in_valid,
    input  logic [7:0]        rx_in_data,
    output logic              rx_in_ready,
    output logic              tx_out_valid,
    output logic [7:0]        tx_out_data,
    input  logic              tx_out_ready,
    output logic              irq
);

    reg_sel_t         sel;
    logic             acc_ok;
    logic             rd_ok;
    logic             wr_ok;
    logic             req_bad;
    logic [7:0]       rx_head;
    logic [LW-1:0]    rx_lvl;
    logic [LW-1:0]    tx_lvl;
    logic             rx_empty, rx_full, tx_empty, tx_full;
    logic             rx_push, rx_pop, tx_push, tx_pop;
    logic [LW-1:0]    rx_lvl_nxt, tx_lvl_nxt;
    logic [IRQ_N-1:0] raw_q;
    logic [IRQ_N-1:0] mask_q;
    logic [IRQ_N-1:0] sw_clr;
    logic [31:0]      be_bits;
    logic [31:0]      mask_word, mask_merged;
    logic [31:0]      clr_word;
    logic [31:0]      flag_word, raw_word, rd_mux;
    logic             unused_bits;

    uart_rf_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    // request qualification: a 64-bit request never has a side effect
    assign acc_ok  = req_valid && (acc_size_e'(req_size) != SZ_DWORD);
    assign rd_ok   = acc_ok && !req_write;
    assign wr_ok   = acc_ok && req_write;
    assign req_bad = (acc_size_e'(req_size) == SZ_DWORD) || sel.miss ||
                     (!req_write && sel.clr);

    // FIFO traffic, qualified by full/empty so the level math is exact
    assign rx_push = rx_in_valid && !rx_full;
    assign rx_pop  = rd_ok && sel.data && !rx_empty;
    assign tx_push = wr_ok && sel.data && req_be[0] && !tx_full;
    assign tx_pop  = tx_out_ready && !tx_empty;

    assign rx_lvl_nxt = rx_lvl + LW'(rx_push) - LW'(rx_pop);
    assign tx_lvl_nxt = tx_lvl + LW'(tx_push) - LW'(tx_pop);

    uart_rf_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (rx_in_data),
        .pop   (rx_pop),
        .head  (rx_head),
        .level (rx_lvl),
        .empty (rx_empty),
        .full  (rx_full)
    );

    uart_rf_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .wdata (req_wdata[7:0]),
        .pop   (tx_pop),
        .head  (tx_out_data),
        .level (tx_lvl),
        .empty (tx_empty),
        .full  (tx_full)
    );

    assign rx_in_ready  = !rx_full;
    assign tx_out_valid = !tx_empty;

    // expand the byte enables to a bit mask, one lane at a time
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign be_bits[8*b +: 8] = {8{req_be[b]}};
    end

    // mask register merge and clear-register bit selection
    assign mask_word   = 32'(mask_q) << IRQ_LSB;
    assign mask_merged = (req_wdata & be_bits) | (mask_word & ~be_bits);
    assign clr_word    = req_wdata & be_bits;
    assign sw_clr      = (wr_ok && sel.clr) ? clr_word[IRQ_LSB +: IRQ_N] : '0;

    // interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= '0;
        else if (wr_ok && sel.mask)  mask_q <= mask_merged[IRQ_LSB +: IRQ_N];
    end

    uart_rf_irq #(.DEPTH(DEPTH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_push    (rx_push),
        .rx_pop     (rx_pop),
        .rx_lvl_nxt (rx_lvl_nxt),
        .tx_push    (tx_push),
        .tx_pop     (tx_pop),
        .tx_lvl_nxt (tx_lvl_nxt),
        .sw_clr     (sw_clr),
        .raw        (raw_q)
    );

    assign irq = |(raw_q & mask_q);

    // flag word built from the fill levels
    always_comb begin
        flag_word           = '0;
        flag_word[FB_BUSY]  = tx_full;
        flag_word[FB_RXEMP] = rx_empty;
        flag_word[FB_TXFUL] = tx_full;
        flag_word[FB_RXFUL] = rx_full;
        flag_word[FB_TXEMP] = tx_empty;
    end

    assign raw_word = 32'(raw_q) << IRQ_LSB;

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (sel.data && !rx_empty) rd_mux = {24'b0, rx_head};
        if (sel.flag)              rd_mux = flag_word;
        if (sel.mask)              rd_mux = mask_word;
        if (sel.raw)               rd_mux = raw_word;
        if (sel.mskd)              rd_mux = raw_word & mask_word;
    end

    // registered response, one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && req_bad;
            rsp_rdata <= (rd_ok && !req_bad) ? rd_mux : '0;
        end
    end

    assign unused_bits = ^{clr_word[31:IRQ_LSB+IRQ_N], clr_word[IRQ_LSB-1:0],
                           mask_merged[31:IRQ_LSB+IRQ_N], mask_merged[IRQ_LSB-1:0]};

endmodule

// File: rtl/uart_regfront_chk.sv
// Module: uart_regfront_chk
// Protocol checks on the ports of uart_regfront. It is attached to the
// top with the bind below and only observes signals.
module uart_regfront_chk
    import uart_regfront_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [31:0]       rsp_rdata,
    input logic              tx_out_valid,
    input logic              tx_out_ready,
    input logic [7:0]        tx_out_data
);

    // R1
    size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> (rsp_err && rsp_rdata == 32'd0));

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R5
    clr_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[ADDR_W-1:2] == (ADDR_W-2)'(WIDX_CLR))
        |=> rsp_err);

    // R4
    rxst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[ADDR_W-1:2] == (ADDR_W-2)'(WIDX_RXST))
        |=> (rsp_rdata == 32'd0));

    // R13
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));

endmodule

bind uart_regfront uart_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .tx_out_data  (tx_out_data)
);

// File: tb/uart_regfront_tb.sv
// Bench: directed scenarios for uart_regfront. There is one task per scenario,
// and each task checks its own results. DEPTH = 8, so the threshold is 4.
module uart_regfront_tb;

    localparam int unsigned ADDR_W = 12;
    localparam logic [11:0] A_DATA = 12'h000, A_RXST = 12'h004, A_FLAG = 12'h018,
                            A_MASK = 12'h038, A_RAW  = 12'h03C, A_MSKD = 12'h040,
                            A_CLR  = 12'h044, A_HOLE = 12'h020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_ready;
    logic        tx_out_valid;
    logic [7:0]  tx_out_data;
    logic        tx_out_ready = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    uart_regfront #(.DEPTH(8), .ADDR_W(ADDR_W)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_size (req_size), .req_be (req_be), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
        .rx_in_valid (rx_in_valid), .rx_in_data (rx_in_data), .rx_in_ready (rx_in_ready),
        .tx_out_valid (tx_out_valid), .tx_out_data (tx_out_data), .tx_out_ready (tx_out_ready),
        .irq (irq)
    );

    // record one comparison
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one bus access; called at a falling edge and returns at the next one
    task automatic bus(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [3:0] be, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = sz; req_be = be; req_wdata = wd;
        @(negedge clk);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 1'b0;
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] rd);
        logic er;
        bus(1'b0, a, 2'd2, 4'hF, 32'd0, rd, er);
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] wd);
        logic [31:0] rd;
        logic er;
        bus(1'b1, a, 2'd2, 4'hF, wd, rd, er);
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_in_valid = 1'b1; rx_in_data = b;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    // reset values of the flag, status and mask words
    task automatic t_reset();
        logic [31:0] v;
        rd32(A_FLAG, v); check("R12 flags after reset", v, 32'h90);
        rd32(A_RAW, v);  check("R12 raw status after reset", v, 32'h0);
        rd32(A_MASK, v); check("R12 mask after reset", v, 32'h0);
    endtask

    // register map corners: rxst, ignored writes, errors, sizes
    task automatic t_map();
        logic [31:0] v;
        logic er;
        wr32(A_RXST, 32'hFFFF_FFFF);
        bus(1'b0, A_RXST, 2'd2, 4'hF, 0, v, er); check("R4 rxst reads 0", v, 0);
        check("R4 rxst no error", 32'(er), 0);
        bus(1'b0, A_DATA, 2'd2, 4'hF, 0, v, er); check("R3 empty data read", v, 0);
        check("R3 empty data read no error", 32'(er), 0);
        bus(1'b0, A_FLAG, 2'd3, 4'hF, 0, v, er); check("R1 64-bit read error", 32'(er), 1);
        check("R1 64-bit read data", v, 0);
        bus(1'b1, A_DATA, 2'd3, 4'hF, 32'h55, v, er); check("R1 64-bit write error", 32'(er), 1);
        rd32(A_FLAG, v); check("R1 64-bit write pushes nothing", v, 32'h90);
        bus(1'b0, A_FLAG, 2'd0, 4'h1, 0, v, er); check("R1 byte read accepted", {v[30:0], er}, {31'h90, 1'b0});
        bus(1'b0, A_FLAG + 12'd1, 2'd1, 4'h3, 0, v, er); check("R1 R6 half read, low bits ignored", {v[30:0], er}, {31'h90, 1'b0});
        bus(1'b0, A_CLR, 2'd2, 4'hF, 0, v, er); check("R5 clear read error", 32'(er), 1);
        bus(1'b0, A_HOLE, 2'd2, 4'hF, 0, v, er); check("R5 unmapped error", {v[30:0], er}, 32'd1);
        wr32(A_FLAG, 32'h0);
        wr32(A_RAW, 32'hFF);
        wr32(A_MSKD, 32'hFF);
        rd32(A_FLAG, v); check("R5 flag write ignored", v, 32'h90);
        rd32(A_RAW, v);  check("R5 raw write ignored", v, 0);
        bus(1'b1, A_DATA, 2'd0, 4'h2, 32'h0000_AA00, v, er);
        rd32(A_FLAG, v); check("R2 no push without lane 0", v, 32'h90);
    endtask

    // transmit fill, overflow drop, drain order, transmit interrupt
    task automatic t_tx();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) wr32(A_DATA, 32'hFFFF_FF00 | 32'(8'hA0 + i));
        rd32(A_RAW, v);  check("R9 TXI set at level 3", v, 32'h20);
        rd32(A_FLAG, v); check("R7 flags tx partial", v, 32'h10);
        for (int i = 3; i < 5; i++) wr32(A_DATA, 32'(8'hA0 + i));
        rd32(A_RAW, v);  check("R9 TXI clear at level 5", v, 0);
        for (int i = 5; i < 8; i++) wr32(A_DATA, 32'(8'hA0 + i));
        rd32(A_FLAG, v); check("R7 full flags with busy", v, 32'h38);
        wr32(A_DATA, 32'hEE);
        tx_out_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            check("R13 R2 tx order, extra byte dropped", {23'd0, tx_out_valid, tx_out_data},
                  {23'd0, 1'b1, 8'(8'hA0 + i)});
            @(negedge clk);
        end
        tx_out_ready = 1'b0;
        check("R13 tx empty after drain", 32'(tx_out_valid), 0);
        rd32(A_FLAG, v); check("R7 flags after drain", v, 32'h90);
        rd32(A_RAW, v);  check("R9 TXI set after drain", v, 32'h20);
        wr32(A_CLR, 32'h20);
        rd32(A_RAW, v);  check("R11 clear removes TXI", v, 0);
    endtask

    // receive fill, refusal when full, thresholds on reads
    task automatic t_rx();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) push_rx(8'(8'h30 + i));
        rd32(A_RAW, v);  check("R10 RTI on pending data", v, 32'h40);
        rd32(A_FLAG, v); check("R7 rx not empty", v, 32'h80);
        push_rx(8'h33);
        rd32(A_RAW, v);  check("R8 RXI at level 4", v, 32'h50);
        for (int i = 4; i < 8; i++) push_rx(8'(8'h30 + i));
        check("R13 rx_in_ready low when full", 32'(rx_in_ready), 0);
        rd32(A_FLAG, v); check("R7 rx full flag", v, 32'hC0);
        push_rx(8'hEE);
        rd32(A_DATA, v); check("R3 first byte", v, 32'h30);
        rd32(A_FLAG, v); check("R7 rx full cleared on read", v, 32'h80);
        rd32(A_RAW, v);  check("R8 RXI kept at level 7", v, 32'h50);
        for (int i = 1; i < 5; i++) begin
            rd32(A_DATA, v); check("R3 R13 rx order", v, 32'(8'h30 + i));
        end
        rd32(A_RAW, v);  check("R8 RXI cleared at level 3", v, 32'h40);
        for (int i = 5; i < 8; i++) begin
            rd32(A_DATA, v); check("R3 R13 rx order tail", v, 32'(8'h30 + i));
        end
        rd32(A_RAW, v);  check("R10 RTI cleared on empty", v, 0);
        rd32(A_FLAG, v); check("R7 rx empty again", v, 32'h90);
        rd32(A_DATA, v); check("R3 refused byte absent", v, 0);
    endtask

    // mask merge, masked status, irq, clear
    task automatic t_mask();
        logic [31:0] v;
        logic er;
        push_rx(8'h77);
        check("R11 irq low while masked", 32'(irq), 0);
        bus(1'b1, A_MASK, 2'd2, 4'hE, 32'hFFFF_FF40, v, er);
        rd32(A_MASK, v); check("R11 mask needs lane 0", v, 0);
        wr32(A_MASK, 32'hFFFF_FF40);
        rd32(A_MASK, v); check("R11 mask keeps bits 6:4", v, 32'h70 & 32'h40);
        rd32(A_MSKD, v); check("R11 masked status", v, 32'h40);
        check("R11 irq high", 32'(irq), 1);
        wr32(A_CLR, 32'h40);
        rd32(A_RAW, v);  check("R11 clear drops RTI", v, 0);
        check("R11 irq low after clear", 32'(irq), 0);
        rd32(A_DATA, v); check("R3 byte still held", v, 32'h77);
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_tx();
        t_rx();
        t_mask();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule